// File: doc/BRIEF.md
# Configuration Test-Port Register Slave

This block is the receiving end of a slow configuration port that software drives by toggling individual control bits. A single 8-bit input bus carries both register codes and register data. The two are told apart by the direction of the test-clock transition together with the level of the enable line. A falling test clock with the enable high captures the bus as the current register code. A rising test clock with the enable low stores the bus into the register that the captured code selects.

The block keeps a small set of 8-bit configuration registers and drives their contents out as configuration outputs:

- one register for the clock lane;
- one register for each data lane;
- one register for the data-lane settle time.

The register picked by the current code is always presented on the read-back bus. A level clear input returns every register and the captured code to zero.

The test clock comes from another timing domain. It passes through a two-flop synchroniser before its edges are detected. The enable and data bus are sampled at the system clock edge on which a test-clock edge is acted on. Software is expected to hold them steady around each test-clock transition.

Top module: `phy_cfg_port_slave`

## Requirements
- R1: A falling edge of the synchronised test clock while `test_en` is 1 captures `test_din` as the current register code. `test_dout` then shows the register that this code selects.
- R2: A rising edge of the synchronised test clock while `test_en` is 0 writes `test_din` into the register selected by the current code.
- R3: A rising edge of the test clock while `test_en` is 1 writes nothing. All configuration outputs and `test_dout` keep their values.
- R4: A falling edge of the test clock while `test_en` is 0 leaves the current register code unchanged.
- R5: While `test_clr` is 1 at a clock edge, every configuration register and the current code become 0x00 and `normal_mode` becomes 1. The clear takes priority over any test-clock edge in the same cycle.
- R6: The writable codes are as follows, and each register drives its own output:
  - code 0x34 drives `clk_lane_cfg`;
  - code 0x75 drives `settle_cfg`;
  - codes 0x44, 0x54, 0x84 and 0x94 drive data lanes 0, 1, 2 and 3, on bits [8i+7:8i] of `data_lane_cfg` for lane i.
- R7: Any other code, including 0x00, reads as 0x00 on `test_dout`, and writes to it change no output.
- R8: `normal_mode` behaves as follows:
  - It is 1 after reset.
  - It goes to 0 when a nonzero code is captured.
  - It returns to 1 when a write (R2) happens while the current code is 0x00.
  - Capturing code 0x00 alone does not change it.
- R9: A test-clock change present at system clock edge n takes effect at edge n+2. This is two synchroniser flops plus one registered action. The enable and data are used as sampled at edge n+2.
- R10: After reset, `test_dout`, `clk_lane_cfg`, `data_lane_cfg` and `settle_cfg` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_clk | input | 1 | Software-toggled test clock, asynchronous |
| test_en | input | 1 | High marks a code (address) phase |
| test_clr | input | 1 | Synchronous clear of registers and code |
| test_din | input | 8 | Shared code/data input bus |
| test_dout | output | 8 | Contents of the currently addressed register |
| clk_lane_cfg | output | 8 | Clock-lane configuration register |
| data_lane_cfg | output | 8*NUM_LANES | Data-lane registers, lane i on bits [8i+7:8i] |
| settle_cfg | output | 8 | Data-lane settle-time register |
| normal_mode | output | 1 | High when the port is in normal operation |

## Verification
The bench runs full code-then-data transactions to every writable code, in the same order software would toggle the control bits. This shows that the edge polarity, not the bus value, decides between capture and write. Crossed patterns then test the enable qualification on its own:

- a rising clock with the enable high must leave every register untouched;
- a falling clock with the enable low must keep the old code.

Further runs write to an unmapped code, write under code 0x00, and pulse the clear after registers hold nonzero values. These separate read-back gating, the normal-mode flag and the clear priority. A behavioural model that keeps a queue of test-clock samples is compared against every output on every cycle, which pins the three-edge latency.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CODE_NORMAL   = 8'h00;
    localparam logic [BYTE_W-1:0] CODE_CLK_LANE = 8'h34;
    localparam logic [BYTE_W-1:0] CODE_SETTLE   = 8'h75;

    // Data-lane codes: lanes 0/1 at 0x44/0x54, lanes 2/3 at 0x84/0x94.
    function automatic logic [BYTE_W-1:0] lane_code(input int idx);
        logic [BYTE_W-1:0] base;
        logic [BYTE_W-1:0] step;
        if (idx < 2) begin
            base = 8'h44;
            step = BYTE_W'(16 * idx);
        end else begin
            base = 8'h84;
            step = BYTE_W'(16 * (idx - 2));
        end
        return base + step;
    endfunction

    // Register slot layout inside the bank: slot 0 clock lane, slot 1 settle,
    // slots 2.. data lanes.
    function automatic logic [BYTE_W-1:0] slot_code(input int slot);
        if (slot == 0) return CODE_CLK_LANE;
        if (slot == 1) return CODE_SETTLE;
        return lane_code(slot - 2);
    endfunction

    typedef struct packed {
        logic [BYTE_W-1:0] code;
        logic              normal;
    } port_ctl_t;

endpackage

// File: rtl/phy_cfg_edge_sync.sv
module phy_cfg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    // STAGES synchroniser flops plus one history flop for edge detection.
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[DEPTH-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign rise =  chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/phy_cfg_reg_bank.sv
module phy_cfg_reg_bank
    import phy_cfg_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        wr_en,
    input  logic [BYTE_W-1:0]           sel_code,
    input  logic [BYTE_W-1:0]           wr_data,
    output logic [BYTE_W-1:0]           rd_data,
    output logic [BYTE_W-1:0]           clk_lane_cfg,
    output logic [NUM_LANES*BYTE_W-1:0] data_lane_cfg,
    output logic [BYTE_W-1:0]           settle_cfg
);
    localparam int NREG = NUM_LANES + 2;

    logic [BYTE_W-1:0] regs_d [NREG];
    logic [BYTE_W-1:0] regs_q [NREG];
    logic [NREG-1:0]   hit;

    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign hit[g] = (sel_code == slot_code(g));
    end

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            if (clr)                   regs_d[i] = '0;
            else if (wr_en && hit[i])  regs_d[i] = wr_data;
            else                       regs_d[i] = regs_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= regs_d[i];
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++) begin
            rd_data = rd_data | (regs_q[i] & {BYTE_W{hit[i]}});
        end
    end

    assign clk_lane_cfg = regs_q[0];
    assign settle_cfg   = regs_q[1];
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign data_lane_cfg[l*BYTE_W +: BYTE_W] = regs_q[l + 2];
    end
endmodule

// File: rtl/phy_cfg_port_slave.sv
module phy_cfg_port_slave
    import phy_cfg_pkg::*;
#(
    parameter int NUM_LANES   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        test_clk,
    input  logic                        test_en,
    input  logic                        test_clr,
    input  logic [7:0]                  test_din,
    output logic [7:0]                  test_dout,
    output logic [7:0]                  clk_lane_cfg,
    output logic [NUM_LANES*8-1:0]      data_lane_cfg,
    output logic [7:0]                  settle_cfg,
    output logic                        normal_mode
);
    logic      tclk_rise, tclk_fall;
    logic      wr_en;
    port_ctl_t ctl_d, ctl_q;
    logic [BYTE_W-1:0] cur_code;

    phy_cfg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (test_clk),
        .rise     (tclk_rise),
        .fall     (tclk_fall)
    );

    always_comb begin
        ctl_d = ctl_q;
        wr_en = 1'b0;
        if (test_clr) begin
            ctl_d.code   = CODE_NORMAL;
            ctl_d.normal = 1'b1;
        end else if (tclk_fall && test_en) begin
            ctl_d.code = test_din;
            if (test_din != CODE_NORMAL) ctl_d.normal = 1'b0;
        end else if (tclk_rise && !test_en) begin
            wr_en = 1'b1;
            if (ctl_q.code == CODE_NORMAL) ctl_d.normal = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.code   <= CODE_NORMAL;
            ctl_q.normal <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cur_code    = ctl_q.code;
    assign normal_mode = ctl_q.normal;

    phy_cfg_reg_bank #(.NUM_LANES(NUM_LANES)) u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr           (test_clr),
        .wr_en         (wr_en),
        .sel_code      (cur_code),
        .wr_data       (test_din),
        .rd_data       (test_dout),
        .clk_lane_cfg  (clk_lane_cfg),
        .data_lane_cfg (data_lane_cfg),
        .settle_cfg    (settle_cfg)
    );
endmodule

// File: rtl/phy_cfg_port_checker.sv
module phy_cfg_port_checker #(
    parameter int LANE_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              test_en,
    input logic              test_clr,
    input logic [7:0]        cur_code,
    input logic [7:0]        clk_lane_cfg,
    input logic [LANE_W-1:0] data_lane_cfg,
    input logic [7:0]        settle_cfg,
    input logic              normal_mode
);
    // R3: enable high at an edge blocks every register write
    p_no_write_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && !test_clr) |=> ($stable(clk_lane_cfg) && $stable(settle_cfg)
                                    && $stable(data_lane_cfg)));

    // R4: the code only moves during an enabled phase or a clear
    p_code_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!test_en && !test_clr) |=> $stable(cur_code));

    // R5: clear zeroes everything
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        test_clr |=> (cur_code == 8'h00 && normal_mode && clk_lane_cfg == 8'h00
                      && settle_cfg == 8'h00 && data_lane_cfg == '0));

    // R8: normal mode re-entered only by clear or a write under code 0x00
    p_normal_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(normal_mode) |-> ($past(test_clr) || (!$past(test_en) && $past(cur_code) == 8'h00)));

    // R8: normal mode left only by capturing a nonzero code
    p_normal_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(normal_mode) |-> ($past(test_en) && cur_code != 8'h00));
endmodule

bind phy_cfg_port_slave phy_cfg_port_checker #(.LANE_W(NUM_LANES*8)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .test_en       (test_en),
    .test_clr      (test_clr),
    .cur_code      (cur_code),
    .clk_lane_cfg  (clk_lane_cfg),
    .data_lane_cfg (data_lane_cfg),
    .settle_cfg    (settle_cfg),
    .normal_mode   (normal_mode)
);

// File: tb/sim_phy_cfg_port_slave.sv
`timescale 1ns/1ps
module sim_phy_cfg_port_slave;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        test_clk = 1;
    logic        test_en = 0;
    logic        test_clr = 0;
    logic [7:0]  test_din = 0;
    logic [7:0]  test_dout;
    logic [7:0]  clk_lane_cfg;
    logic [31:0] data_lane_cfg;
    logic [7:0]  settle_cfg;
    logic        normal_mode;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    phy_cfg_port_slave u0 (
        .clk(clk), .rst_n(rst_n), .test_clk(test_clk), .test_en(test_en),
        .test_clr(test_clr), .test_din(test_din), .test_dout(test_dout),
        .clk_lane_cfg(clk_lane_cfg), .data_lane_cfg(data_lane_cfg),
        .settle_cfg(settle_cfg), .normal_mode(normal_mode)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] m_reg [256];
    logic [7:0] m_code;
    logic       m_norm;
    int         hist [$];

    function automatic bit known(input logic [7:0] c);
        return c == 8'h34 || c == 8'h75 || c == 8'h44 || c == 8'h54 ||
               c == 8'h84 || c == 8'h94;
    endfunction

    task automatic m_clear();
        for (int i = 0; i < 256; i++) m_reg[i] = 8'h00;
        m_code = 8'h00;
        m_norm = 1'b1;
    endtask

    initial begin
        m_clear();
        hist = '{0, 0, 0};
    end

    always @(posedge clk) begin
        int n;
        bit rise, fall;
        n = hist.size();
        rise = hist[n-2] == 1 && hist[n-3] == 0;
        fall = hist[n-2] == 0 && hist[n-3] == 1;
        hist.push_back(rst_n ? int'(test_clk) : 0);
        if (hist.size() > 8) void'(hist.pop_front());
        if (!rst_n) m_clear();
        else if (test_clr) m_clear();
        else if (fall && test_en) begin
            m_code = test_din;
            if (test_din != 8'h00) m_norm = 1'b0;
        end else if (rise && !test_en) begin
            if (known(m_code)) m_reg[m_code] = test_din;
            if (m_code == 8'h00) m_norm = 1'b1;
        end
    end

    // R9: cycle-accurate comparison of every output
    always @(negedge clk) begin
        logic [7:0]  e_dout;
        logic [31:0] e_lanes;
        if (rst_n && !done) begin
            e_dout  = known(m_code) ? m_reg[m_code] : 8'h00;
            e_lanes = {m_reg[8'h94], m_reg[8'h84], m_reg[8'h54], m_reg[8'h44]};
            checks++;
            if (test_dout !== e_dout || clk_lane_cfg !== m_reg[8'h34] ||
                settle_cfg !== m_reg[8'h75] || data_lane_cfg !== e_lanes ||
                normal_mode !== m_norm) begin
                failures++;
                $display("FAIL R9 cycle t=%0t actual dout=%h clk=%h lanes=%h settle=%h nm=%b expected dout=%h clk=%h lanes=%h settle=%h nm=%b",
                         $time, test_dout, clk_lane_cfg, data_lane_cfg, settle_cfg, normal_mode,
                         e_dout, m_reg[8'h34], e_lanes, m_reg[8'h75], m_norm);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_reg(input logic [7:0] code, input logic [7:0] data);
        test_clk = 1; hold(6);
        test_din = code; test_en = 1; hold(6);
        test_clk = 0; hold(6);
        test_en = 0; hold(6);
        test_din = data; hold(6);
        test_clk = 1; hold(6);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            summary();
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] snap_lanes;
        hold(5);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        chk("R10 dout", test_dout, 0);
        chk("R10 clk_lane", clk_lane_cfg, 0);
        chk("R10 lanes", data_lane_cfg, 0);
        chk("R10 settle", settle_cfg, 0);
        chk("R8 normal after reset", normal_mode, 1);
        hold(4);

        // R2 / R6: every writable code
        write_reg(8'h34, 8'h11);
        write_reg(8'h44, 8'h22);
        write_reg(8'h54, 8'h33);
        write_reg(8'h84, 8'h44);
        write_reg(8'h94, 8'h55);
        write_reg(8'h75, 8'h04);
        chk("R6 clk_lane", clk_lane_cfg, 32'h11);
        chk("R6 lanes", data_lane_cfg, 32'h55443322);
        chk("R2 settle", settle_cfg, 32'h04);
        chk("R1 dout addressed", test_dout, 32'h04);
        chk("R8 normal left", normal_mode, 0);

        // R1 + R9: capture code 0x54, latency of three edges
        test_en = 1; test_din = 8'h54; hold(6);
        test_clk = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R9 not yet", test_dout, 32'h04);
        @(negedge clk);
        chk("R1 captured", test_dout, 32'h33);
        hold(6);

        // R3: rising clock with enable high
        test_din = 8'h99; hold(6);
        test_clk = 1; hold(8);
        chk("R3 dout", test_dout, 32'h33);
        chk("R3 lanes", data_lane_cfg, 32'h55443322);

        // R4: falling clock with enable low
        test_en = 0; test_din = 8'h77; hold(6);
        test_clk = 0; hold(8);
        chk("R4 code held", test_dout, 32'h33);
        test_clk = 1; hold(8);
        chk("R2 lane1 write", data_lane_cfg, 32'h55447722);

        // R7: unmapped code
        snap_lanes = data_lane_cfg;
        write_reg(8'h60, 8'hFF);
        chk("R7 dout zero", test_dout, 0);
        chk("R7 lanes", data_lane_cfg, snap_lanes);
        chk("R7 clk_lane", clk_lane_cfg, 32'h11);
        chk("R7 settle", settle_cfg, 32'h04);

        // R8: write under code 0x00
        chk("R8 still test", normal_mode, 0);
        write_reg(8'h00, 8'h00);
        chk("R8 back normal", normal_mode, 1);
        chk("R7 code0 reads zero", test_dout, 0);

        // R5: clear
        write_reg(8'h94, 8'hA5);
        test_clr = 1; hold(1);
        test_clr = 0;
        @(negedge clk);
        chk("R5 lanes", data_lane_cfg, 0);
        chk("R5 clk_lane", clk_lane_cfg, 0);
        chk("R5 settle", settle_cfg, 0);
        chk("R5 normal", normal_mode, 1);
        chk("R5 dout", test_dout, 0);
        hold(4);
        write_reg(8'h34, 8'h5C);
        chk("R2 after clear", clk_lane_cfg, 32'h5C);

        hold(4);
        done = 1;
        summary();
    end
endmodule